// File: doc/BRIEF.md
# Dual-Role Byte Serial Port Controller

This block moves one byte at a time over a four-wire synchronous serial link, in both directions at once. A control input picks its role. As bus master it makes the serial clock from the system clock through a power-of-two divider. It pulls its own select line low for the whole frame and starts a frame whenever the host writes a byte while nothing is shifting. As bus slave it follows a clock and select driven by another device. It brings both into its own clock domain through two-flop synchronizers and shifts on the synchronized edges.

Both roles share one eight-bit shift register. Data moves most significant bit first. The clock idles low, input bits are taken on the rising edge and output bits change after the falling edge. When a frame ends, the received byte is copied into a read buffer on the same clock that raises the done flag. The buffer keeps that byte until the next frame completes. The flag stays up until the host pulses a clear strobe.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: After reset, done_flag, busy, sck_o, mosi_o and miso_o are 0, ss_n_o is 1 and rd_data is 0x00.
- R2: With ctrl_en=1 and ctrl_master=1, a wr_en pulse while busy=0 starts a frame. ss_n_o goes low and the eight bits of wr_data leave on mosi_o most significant bit first. Each bit is stable at a rising edge of sck_o, and sck_o is low whenever ss_n_o is high.
- R3: During a master frame, miso_i is sampled at each rising sck_o edge, most significant bit first. After the frame, rd_data holds the eight sampled bits.
- R4: A master frame ends on the eighth falling edge of sck_o. In that same clock, done_flag is set, ss_n_o returns high and rd_data takes the received byte.
- R5: In master mode the sck_o period is 4 << ctrl_div system clocks: 4 clocks for ctrl_div=0 and 32 clocks for ctrl_div=3.
- R6: A wr_en pulse while busy=1 in master mode has no effect. The byte on mosi_o is unchanged and no further frame follows.
- R7: rd_data changes only when a frame completes. An aborted frame leaves it unchanged.
- R8: A flag_clr pulse clears done_flag. If a frame completes in the same clock, the flag stays set.
- R9: With ctrl_master=0 and ss_n_i low, the block shifts in mosi_i on each synchronized rising edge of sck_i. It drives the last written byte on miso_o most significant bit first, updating after each falling edge. It sets done_flag and loads rd_data after the eighth rising edge.
- R10: If ss_n_i rises before the eighth rising edge in slave mode, the partial byte is dropped and done_flag is not set. The next frame starts from bit 0.
- R11: With ctrl_en=0, wr_en starts no frame and slave clock activity causes no transfer; busy stays 0.
- R12: In slave mode sck_o and mosi_o are 0 and ss_n_o is 1. In master mode miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ctrl_en | input | 1 | Block enable |
| ctrl_master | input | 1 | 1 = master role, 0 = slave role |
| ctrl_div | input | 2 | Serial clock divider select, period 4 << ctrl_div clocks |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clears the done flag |
| rd_data | output | 8 | Read buffer, last received byte |
| done_flag | output | 1 | Frame completion flag |
| busy | output | 1 | Shift register occupied |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_o | output | 1 | Active-low select out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_n_i | input | 1 | Active-low select in (slave) |

## Verification
Master frames are run with opposite byte pairs such as 0xA5 against 0x3C and 0xFF against 0x00. This shows that the two directions travel in the same frame without mixing, and that the bit order is most significant first. The fastest and slowest divider settings show the period scaling. A second write injected mid-frame shows whether an occupied shift register can be overwritten. Slave frames run whole, aborted after four bits, and then whole again. Together these separate a clean capture, a discarded partial byte with an unchanged buffer, and a bit counter that really restarts.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } xfer_st_t;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   lim;

  always_comb begin
    lim  = (CNT_W+1)'(1) << (int'(sel) + 1);
    lim  = lim - (CNT_W+1)'(1);
    tick = run && ({1'b0, cnt_q} == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d[g];
        s2_q <= s1_q;
      end
    end
    assign q[g] = s2_q;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_duplex_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            master,
  input  logic            start,
  input  logic [BITS-1:0] load_byte,
  input  logic            tick,
  input  logic            miso_in,
  input  logic            s_rise,
  input  logic            s_fall,
  input  logic            s_ss_n,
  input  logic            s_mosi,
  output logic            sck_q,
  output logic            obit_q,
  output logic            frame_act,
  output logic            div_run,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BITS + 1);

  xfer_st_t        st_q, st_d;
  logic [BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            sck_d, obit_d;

  always_comb begin
    st_d   = st_q;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    obit_d = obit_q;
    done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en && ((master && start) || (!master && !s_ss_n))) begin
          sr_d   = load_byte;
          obit_d = load_byte[BITS-1];
          cnt_d  = '0;
          sck_d  = 1'b0;
          st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!en) begin
          st_d  = ST_IDLE;
          sck_d = 1'b0;
          cnt_d = '0;
        end else if (master) begin
          if (tick) begin
            if (!sck_q) begin
              sck_d = 1'b1;
              sr_d  = {sr_q[BITS-2:0], miso_in};
              cnt_d = cnt_q + CNT_W'(1);
            end else begin
              sck_d = 1'b0;
              if (cnt_q == CNT_W'(BITS)) begin
                done  = 1'b1;
                cnt_d = '0;
                st_d  = ST_IDLE;
              end else begin
                obit_d = sr_q[BITS-1];
              end
            end
          end
        end else begin
          if (s_ss_n) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (s_rise) begin
            sr_d  = {sr_q[BITS-2:0], s_mosi};
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BITS - 1)) begin
              done  = 1'b1;
              cnt_d = '0;
              st_d  = ST_HOLD;
            end
          end else if (s_fall) begin
            obit_d = sr_q[BITS-1];
          end
        end
      end
      ST_HOLD: begin
        if (!en || s_ss_n || master) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      obit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      obit_q <= obit_d;
    end
  end

  assign rx_byte   = sr_d;
  assign frame_act = (st_q == ST_RUN);
  assign busy      = (st_q != ST_IDLE);
  assign div_run   = frame_act && master;
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl #(
  parameter int DATA_W    = 8,
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_en,
  input  logic                 ctrl_master,
  input  logic [DIV_SEL_W-1:0] ctrl_div,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 flag_clr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 done_flag,
  output logic                 busy,
  output logic                 sck_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic                 ss_n_o,
  input  logic                 sck_i,
  input  logic                 mosi_i,
  output logic                 miso_o,
  input  logic                 ss_n_i
);
  localparam int SYNC_W = 3;

  logic [DATA_W-1:0] tx_hold_q, tx_hold_d;
  logic [DATA_W-1:0] rd_buf_q, rd_buf_d;
  logic              flag_q, flag_d;
  logic              sck_prev_q;
  logic [SYNC_W-1:0] sync_in, sync_out;
  logic              s_sck, s_ss_n, s_mosi, s_rise, s_fall;
  logic              tick, div_run, sck_q, obit_q, frame_act, done_pulse, start;
  logic [DATA_W-1:0] rx_byte, load_byte;

  assign sync_in = {ss_n_i, mosi_i, sck_i};

  spi_sync #(.W(SYNC_W), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );

  assign s_sck  = sync_out[0];
  assign s_mosi = sync_out[1];
  assign s_ss_n = sync_out[2];
  assign s_rise = s_sck && !sck_prev_q;
  assign s_fall = !s_sck && sck_prev_q;

  spi_sck_div #(.SEL_W(DIV_SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(div_run), .sel(ctrl_div), .tick(tick)
  );

  assign start     = wr_en && ctrl_en && ctrl_master && !busy;
  assign load_byte = ctrl_master ? wr_data : tx_hold_q;

  spi_shift_core #(.BITS(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .master(ctrl_master),
    .start(start), .load_byte(load_byte), .tick(tick), .miso_in(miso_i),
    .s_rise(s_rise), .s_fall(s_fall), .s_ss_n(s_ss_n), .s_mosi(s_mosi),
    .sck_q(sck_q), .obit_q(obit_q), .frame_act(frame_act),
    .div_run(div_run), .busy(busy), .done(done_pulse), .rx_byte(rx_byte)
  );

  always_comb begin
    tx_hold_d = wr_en ? wr_data : tx_hold_q;
    rd_buf_d  = done_pulse ? rx_byte : rd_buf_q;
    if (done_pulse)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold_q  <= '0;
      rd_buf_q   <= '0;
      flag_q     <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      tx_hold_q  <= tx_hold_d;
      rd_buf_q   <= rd_buf_d;
      flag_q     <= flag_d;
      sck_prev_q <= s_sck;
    end
  end

  assign rd_data   = rd_buf_q;
  assign done_flag = flag_q;
  assign sck_o     = ctrl_master && sck_q;
  assign mosi_o    = ctrl_master && frame_act && obit_q;
  assign ss_n_o    = !(ctrl_master && frame_act);
  assign miso_o    = !ctrl_master && frame_act && obit_q;
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              ctrl_master,
  input logic              flag_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              done_flag,
  input logic              busy,
  input logic              sck_o,
  input logic              ss_n_o,
  input logic              done_pulse
);
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> !sck_o);

  assert_done_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && ctrl_master) |=> (ss_n_o && done_flag));

  assert_buf_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> $stable(rd_data));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done_pulse) |=> !done_flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_flag);

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !busy) |=> !busy);
endmodule

bind spi_duplex_ctrl spi_duplex_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_master(ctrl_master),
  .flag_clr(flag_clr), .rd_data(rd_data), .done_flag(done_flag),
  .busy(busy), .sck_o(sck_o), .ss_n_o(ss_n_o), .done_pulse(done_pulse)
);

// File: tb/spi_duplex_ctrl_bench.sv
module spi_duplex_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_en = 1'b0, ctrl_master = 1'b0;
  logic [1:0] ctrl_div = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic [7:0] rd_data;
  logic       done_flag, busy, sck_o, mosi_o, ss_n_o, miso_o;
  logic       miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_duplex_ctrl u_spi_duplex_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_master(ctrl_master),
    .ctrl_div(ctrl_div), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .rd_data(rd_data), .done_flag(done_flag), .busy(busy), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o), .sck_i(sck_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done_flag == 1'b0, "R1 flag", done_flag, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(ss_n_o == 1'b1 && sck_o == 1'b0, "R1 ss/sck", {ss_n_o, sck_o}, 2'b10);
    chk(mosi_o == 1'b0 && miso_o == 1'b0, "R1 data lines", {mosi_o, miso_o}, 0);
  endtask

  task automatic t_master(input logic [7:0] tx, input logic [7:0] sb,
                          input logic [1:0] div, input bit inject);
    logic [7:0] rx = 8'h00;
    time t0 = 0, t1 = 0;
    bit  saw_miso = 1'b0;
    ctrl_en = 1'b1; ctrl_master = 1'b1; ctrl_div = div;
    miso_i = sb[7];
    @(negedge clk) begin wr_en = 1'b1; wr_data = tx; end
    @(negedge clk) wr_en = 1'b0;
    chk(ss_n_o == 1'b0, "R2 ss low in frame", ss_n_o, 0);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      rx = {rx[6:0], mosi_o};
      if (i == 0) t0 = $time;
      if (i == 1) t1 = $time;
      if (miso_o) saw_miso = 1'b1;
      if (inject && i == 2) begin
        @(negedge clk) begin wr_en = 1'b1; wr_data = ~tx; end
        @(negedge clk) wr_en = 1'b0;
      end
      @(negedge sck_o);
      if (i < 7) miso_i = sb[6-i];
    end
    @(negedge clk);
    chk(rx == tx, "R2 mosi byte", rx, tx);
    chk(done_flag == 1'b1, "R4 flag at last fall", done_flag, 1);
    chk(ss_n_o == 1'b1, "R4 ss high at end", ss_n_o, 1);
    chk(rd_data == sb, "R3 received byte", rd_data, sb);
    chk((t1 - t0) == time'(32 << div), "R5 sck period",
        int'(t1 - t0), 32 << div);
    chk(!saw_miso, "R12 miso low in master", saw_miso, 0);
    if (inject) begin
      repeat (60) @(negedge clk);
      chk(busy == 1'b0 && ss_n_o == 1'b1, "R6 no second frame", busy, 0);
    end
    clr_flag();
    @(negedge clk);
    chk(done_flag == 1'b0, "R8 clear strobe", done_flag, 0);
  endtask

  task automatic t_slave(input logic [7:0] hold, input logic [7:0] mtx,
                         input int nbits, input logic [7:0] prev_rd);
    logic [7:0] rx = 8'h00;
    ctrl_en = 1'b1; ctrl_master = 1'b0;
    @(negedge clk) begin wr_en = 1'b1; wr_data = hold; end
    @(negedge clk) wr_en = 1'b0;
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(sck_o == 1'b0 && ss_n_o == 1'b1 && mosi_o == 1'b0, "R12 slave master pins",
        {sck_o, ss_n_o, mosi_o}, 3'b010);
    for (int i = 0; i < nbits; i++) begin
      rx = {rx[6:0], miso_o};
      mosi_i = mtx[7-i];
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    if (nbits == 8) begin
      chk(done_flag == 1'b1, "R9 slave flag", done_flag, 1);
      chk(rd_data == mtx, "R9 slave rx", rd_data, mtx);
      chk(rx == hold, "R9 slave miso byte", rx, hold);
    end else begin
      ss_n_i = 1'b1;
      repeat (8) @(negedge clk);
      chk(done_flag == 1'b0, "R10 abort no flag", done_flag, 0);
      chk(rd_data == prev_rd, "R7 buffer kept on abort", rd_data, prev_rd);
    end
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    clr_flag();
  endtask

  task automatic t_disabled();
    ctrl_en = 1'b0; ctrl_master = 1'b1;
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h5A; end
    @(negedge clk) wr_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && ss_n_o == 1'b1 && sck_o == 1'b0, "R11 master write ignored",
        {busy, ss_n_o, sck_o}, 3'b010);
    ctrl_master = 1'b0; ss_n_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (6) @(negedge clk); sck_i = 1'b1;
      repeat (6) @(negedge clk); sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && done_flag == 1'b0, "R11 slave ignored", {busy, done_flag}, 0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master(8'hA5, 8'h3C, 2'd0, 1'b0);
    t_master(8'hFF, 8'h00, 2'd3, 1'b0);
    t_master(8'h81, 8'h7E, 2'd2, 1'b1);
    t_slave(8'hC3, 8'h96, 8, 8'h7E);
    t_slave(8'h0F, 8'hF0, 4, 8'h96);
    t_slave(8'h69, 8'h2D, 8, 8'h96);
    t_disabled();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule